// File: doc/BRIEF.md
# Transition-safe tristate pin driver

This block turns the configuration of one general-purpose I/O pin into the three pad controls: output enable, output data and pull-up enable. It also gives a 3-bit code naming the resolved signal state in the nine-value logic style. The pin has two independent controls. The drive control selects active or tristate, and the level control selects high or low. Each control is set either by a constant or by a selected signal net from a bus of net values. A net value that is nonzero in any bit counts as active or high. A selector that points past the last net reads as zero.

A hardware capability count for each control can lock it. When the count is zero, that control takes a fixed value from a dedicated input and disregards the requested setting. An open-collector pin is one example: its level is fixed low and only its drive can toggle.

When a request changes both controls at once, the block spreads the change over two cycles. Its order keeps the pad from ever showing a driven state that is neither the old state nor the new one. In particular, moving between pulled-up tristate and driven low always passes through undriven low and never through driven high. Every pad output comes from a register.

Top module: `tsafe_pin_drv`

## Requirements
- R1: While reset is asserted, pad_oe, pad_do and pad_pu are 0 and pin_code is 4 (high impedance).
- R2: The resolved state maps to the outputs as follows:
  - active high: oe=1, do=1, pu=0, code 1;
  - active low: oe=1, do=0, pu=0, code 0;
  - tristate high: oe=0, do=1, pu=1, code 3;
  - tristate low: oe=0, do=0, pu=0. Its code is 2 (weak low) when pd_present is 1 and 4 otherwise.
- R3: With a control's follow input at 0, the control takes its constant input. For mode, 1 means active; for level, 1 means high.
- R4: With a control's follow input at 1, the control is active or high exactly when the selected net value is nonzero in any bit, including only bit 31 set.
- R5: A net selector whose value is NUM_NETS or more reads as zero, whatever the net values are.
- R6: A control whose capability count is zero takes its fixed input and ignores its constant and net inputs.
- R7: A request that changes only one control shows on the pad outputs after the next rising clock edge.
- R8: A change from tristate high to active low shows tristate low for exactly one cycle, then active low. It never shows active high.
- R9: A change from active low to tristate high shows tristate low for exactly one cycle, then tristate high.
- R10: Other requests that change both controls take two steps. When the drive is being enabled, the level changes first. When the drive is being released, the drive changes first. Tristate low to active high passes through tristate high, and active high to tristate low also passes through tristate high.
- R11: Between consecutive cycles, at most one of drive and level changes on the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| net_vals | input | NUM_NETS x NET_W | Current value of every signal net |
| mode_follow | input | 1 | 1: drive control follows a net; 0: it uses mode_const |
| mode_const | input | 1 | Constant drive request, 1 = active |
| mode_sel | input | SEL_W | Net index for the drive control |
| mode_cap_cnt | input | CAP_W | Drive capability count; zero locks the drive |
| mode_fixed | input | 1 | Locked drive value, 1 = active |
| level_follow | input | 1 | 1: level follows a net; 0: it uses level_const |
| level_const | input | 1 | Constant level request, 1 = high |
| level_sel | input | SEL_W | Net index for the level control |
| level_cap_cnt | input | CAP_W | Level capability count; zero locks the level |
| level_fixed | input | 1 | Locked level value, 1 = high |
| pd_present | input | 1 | Pin has a pull-down, so tristate low reads weak low |
| pad_oe | output | 1 | Pad output enable |
| pad_do | output | 1 | Pad output data |
| pad_pu | output | 1 | Pad pull-up enable |
| pin_code | output | 3 | Resolved state: 0 forcing 0, 1 forcing 1, 2 weak 0, 3 weak 1, 4 high impedance |

## Verification
The hardest situation to reach is the one-cycle intermediate state of a two-control change, because it lasts only one cycle. The stimulus first settles the pin in a known corner with a single-control change. It then flips both constants in the same cycle and samples the outputs after each of the next two edges. This is done for all four diagonal moves. Net binding, out-of-range selectors and locked controls are each reached by changing one input at a time from a settled state, so the expected state is always known.

// File: rtl/pin_drv_pkg.sv
package pin_drv_pkg;

  typedef enum logic [2:0] {
    CODE_F0 = 3'd0,
    CODE_F1 = 3'd1,
    CODE_WL = 3'd2,
    CODE_WH = 3'd3,
    CODE_HZ = 3'd4
  } pin_code_e;

  typedef struct packed {
    logic act;
    logic hi;
  } drv_st_t;

  localparam drv_st_t ST_TL = '{act: 1'b0, hi: 1'b0};

  // Resolved state code for a drive state
  function automatic pin_code_e state_code(input drv_st_t s, input logic pd);
    pin_code_e c;
    if (s.act) c = s.hi ? CODE_F1 : CODE_F0;
    else if (s.hi) c = CODE_WH;
    else c = pd ? CODE_WL : CODE_HZ;
    return c;
  endfunction

  // Next step toward a target: at most one control moves per step
  function automatic drv_st_t next_step(input drv_st_t cur, input drv_st_t tgt);
    drv_st_t n;
    n = tgt;
    if ((cur.act != tgt.act) && (cur.hi != tgt.hi)) begin
      if (tgt.act) n = '{act: cur.act, hi: tgt.hi};
      else n = '{act: tgt.act, hi: cur.hi};
    end
    return n;
  endfunction

endpackage

// File: rtl/ctl_resolve.sv
module ctl_resolve #(
  parameter int NUM_NETS = 8,
  parameter int NET_W    = 32,
  parameter int SEL_W    = 4,
  parameter int CAP_W    = 2
) (
  input  logic [NUM_NETS-1:0][NET_W-1:0] net_vals,
  input  logic                           follow,
  input  logic                           const_val,
  input  logic [SEL_W-1:0]               sel,
  input  logic [CAP_W-1:0]               cap_cnt,
  input  logic                           fixed_val,
  output logic                           ctl_out,
  output logic                           locked
);

  // Selected net read as a truth value; absent index reads zero
  function automatic logic pick_net(input logic [NUM_NETS-1:0][NET_W-1:0] nv,
                                    input logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_NETS; i++) begin
      if (s == SEL_W'(i)) r = |nv[i];
    end
    return r;
  endfunction

  logic net_bit;
  logic req_bit;

  always_comb begin
    net_bit = pick_net(net_vals, sel);
    req_bit = follow ? net_bit : const_val;
    locked  = (cap_cnt == '0);
    ctl_out = locked ? fixed_val : req_bit;
  end

endmodule

// File: rtl/drv_sequencer.sv
module drv_sequencer
  import pin_drv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  drv_st_t tgt,
  output drv_st_t st_d,
  output drv_st_t st_q
);

  logic [1:0] run_cnt;
  logic       split_w;

  assign split_w = (st_q.act != tgt.act) && (st_q.hi != tgt.hi);

  always_comb begin
    st_d = next_step(st_q, tgt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_TL;
      run_cnt <= 2'd0;
    end else begin
      st_q <= st_d;
      if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end
  end

  // R8
  no_th_to_al_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.act == 1'b0 && st_q.hi == 1'b1) |=> !(st_q.act == 1'b1 && st_q.hi == 1'b0));

  // R9
  no_al_to_th_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.act == 1'b1 && st_q.hi == 1'b0) |=> !(st_q.act == 1'b0 && st_q.hi == 1'b1));

  // R11
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt != 2'd0) |-> ($countones(st_q ^ $past(st_q)) <= 1));

  // R10
  split_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_w |=> (st_q != $past(tgt)));

  // R7
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == 2'd3 && tgt == $past(tgt) && $past(tgt) == $past(tgt, 2))
      |=> (st_q == $past(tgt)));

endmodule

// File: rtl/pad_out_reg.sv
module pad_out_reg
  import pin_drv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  drv_st_t st_d,
  input  logic    pd_present,
  output logic    pad_oe,
  output logic    pad_do,
  output logic    pad_pu,
  output logic [2:0] pin_code
);

  pin_code_e code_d;

  always_comb begin
    code_d = state_code(st_d, pd_present);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_oe   <= 1'b0;
      pad_do   <= 1'b0;
      pad_pu   <= 1'b0;
      pin_code <= 3'(CODE_HZ);
    end else begin
      pad_oe   <= st_d.act;
      pad_do   <= st_d.hi;
      pad_pu   <= !st_d.act && st_d.hi;
      pin_code <= 3'(code_d);
    end
  end

  // R2
  pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_pu |-> !pad_oe);

  // R2
  code_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_code <= 3'd1) |-> (pad_oe && (pad_do == pin_code[0])));

  // R1
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_code <= 3'd4);

endmodule

// File: rtl/tsafe_pin_drv.sv
module tsafe_pin_drv
  import pin_drv_pkg::*;
#(
  parameter int NUM_NETS = 8,
  parameter int NET_W    = 32,
  parameter int CAP_W    = 2,
  localparam int SEL_W   = $clog2(NUM_NETS) + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_NETS-1:0][NET_W-1:0] net_vals,
  input  logic                           mode_follow,
  input  logic                           mode_const,
  input  logic [SEL_W-1:0]               mode_sel,
  input  logic [CAP_W-1:0]               mode_cap_cnt,
  input  logic                           mode_fixed,
  input  logic                           level_follow,
  input  logic                           level_const,
  input  logic [SEL_W-1:0]               level_sel,
  input  logic [CAP_W-1:0]               level_cap_cnt,
  input  logic                           level_fixed,
  input  logic                           pd_present,
  output logic                           pad_oe,
  output logic                           pad_do,
  output logic                           pad_pu,
  output logic [2:0]                     pin_code
);

  logic    mode_w, level_w;
  logic    mode_lock_w, level_lock_w;
  drv_st_t tgt_w, st_d_w, st_q_w;

  ctl_resolve #(.NUM_NETS(NUM_NETS), .NET_W(NET_W), .SEL_W(SEL_W), .CAP_W(CAP_W)) mode_ctl_i (
    .net_vals (net_vals),
    .follow   (mode_follow),
    .const_val(mode_const),
    .sel      (mode_sel),
    .cap_cnt  (mode_cap_cnt),
    .fixed_val(mode_fixed),
    .ctl_out  (mode_w),
    .locked   (mode_lock_w)
  );

  ctl_resolve #(.NUM_NETS(NUM_NETS), .NET_W(NET_W), .SEL_W(SEL_W), .CAP_W(CAP_W)) level_ctl_i (
    .net_vals (net_vals),
    .follow   (level_follow),
    .const_val(level_const),
    .sel      (level_sel),
    .cap_cnt  (level_cap_cnt),
    .fixed_val(level_fixed),
    .ctl_out  (level_w),
    .locked   (level_lock_w)
  );

  assign tgt_w = '{act: mode_w, hi: level_w};

  drv_sequencer seq_i (
    .clk  (clk),
    .rst_n(rst_n),
    .tgt  (tgt_w),
    .st_d (st_d_w),
    .st_q (st_q_w)
  );

  pad_out_reg out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_d      (st_d_w),
    .pd_present(pd_present),
    .pad_oe    (pad_oe),
    .pad_do    (pad_do),
    .pad_pu    (pad_pu),
    .pin_code  (pin_code)
  );

  // R6
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_lock_w |-> (mode_w == mode_fixed));

  // R6
  level_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_lock_w |-> (level_w == level_fixed));

  // R2
  pad_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe == st_q_w.act) && (pad_do == st_q_w.hi));

endmodule

// File: tb/tsafe_pin_drv_tb_top.sv
module tsafe_pin_drv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NN = 8;
  localparam int NW = 32;
  localparam int CW = 2;
  localparam int SW = $clog2(NN) + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NN-1:0][NW-1:0] net_vals;
  logic mode_follow, mode_const, mode_fixed;
  logic level_follow, level_const, level_fixed;
  logic [SW-1:0] mode_sel, level_sel;
  logic [CW-1:0] mode_cap_cnt, level_cap_cnt;
  logic pd_present;
  logic pad_oe, pad_do, pad_pu;
  logic [2:0] pin_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsafe_pin_drv #(.NUM_NETS(NN), .NET_W(NW), .CAP_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .net_vals(net_vals),
    .mode_follow(mode_follow), .mode_const(mode_const), .mode_sel(mode_sel),
    .mode_cap_cnt(mode_cap_cnt), .mode_fixed(mode_fixed),
    .level_follow(level_follow), .level_const(level_const), .level_sel(level_sel),
    .level_cap_cnt(level_cap_cnt), .level_fixed(level_fixed),
    .pd_present(pd_present),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .pin_code(pin_code)
  );

  // Expected pad view for drive a / level h, from R2
  function automatic logic [5:0] expect_of(input logic a, input logic h, input logic pd);
    logic [2:0] c;
    if (a) c = h ? 3'd1 : 3'd0;
    else if (h) c = 3'd3;
    else c = pd ? 3'd2 : 3'd4;
    return {a, h, (!a && h), c};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic a, input logic h);
    logic [5:0] e, g;
    e = expect_of(a, h, pd_present);
    g = {pad_oe, pad_do, pad_pu, pin_code};
    total++;
    if (g !== e) begin
      bad++;
      $display("FAIL %s: oe/do/pu/code got %b/%b/%b/%0d expected %b/%b/%b/%0d",
               req, g[5], g[4], g[3], g[2:0], e[5], e[4], e[3], e[2:0]);
    end
  endtask

  task automatic set_const(input logic a, input logic h);
    mode_const = a;
    level_const = h;
  endtask

  task automatic t_reset();
    total++;
    if ({pad_oe, pad_do, pad_pu, pin_code} !== {3'b000, 3'd4}) begin
      bad++;
      $display("FAIL R1: got %b%b%b/%0d expected 000/4", pad_oe, pad_do, pad_pu, pin_code);
    end
  endtask

  task automatic t_single();
    set_const(1'b0, 1'b1); step(); check("R7 R3 R2 TL->TH", 1'b0, 1'b1);
    set_const(1'b1, 1'b0); step(); check("R8 mid", 1'b0, 1'b0);
    step(); check("R8 end", 1'b1, 1'b0);
    set_const(1'b1, 1'b1); step(); check("R7 R2 AL->AH", 1'b1, 1'b1);
    set_const(1'b1, 1'b0); step(); check("R7 AH->AL", 1'b1, 1'b0);
  endtask

  task automatic t_al_to_th();
    set_const(1'b0, 1'b1); step(); check("R9 mid", 1'b0, 1'b0);
    step(); check("R9 end", 1'b0, 1'b1);
    set_const(1'b0, 1'b0); step(); check("R7 TH->TL", 1'b0, 1'b0);
  endtask

  task automatic t_diag();
    set_const(1'b1, 1'b1); step(); check("R10 TL->AH mid", 1'b0, 1'b1);
    step(); check("R10 TL->AH end", 1'b1, 1'b1);
    set_const(1'b0, 1'b0); step(); check("R10 AH->TL mid", 1'b0, 1'b1);
    step(); check("R10 AH->TL end", 1'b0, 1'b0);
  endtask

  task automatic t_pd();
    pd_present = 1'b1; step(); check("R2 pull-down", 1'b0, 1'b0);
    pd_present = 1'b0; step(); check("R2 no pull", 1'b0, 1'b0);
  endtask

  task automatic t_net();
    mode_follow = 1'b1; mode_sel = SW'(3); mode_const = 1'b1;
    step(); check("R4 zero net", 1'b0, 1'b0);
    net_vals[3] = 32'h8000_0000; step(); check("R4 bit31", 1'b1, 1'b0);
    net_vals[3] = '0; step(); check("R4 cleared", 1'b0, 1'b0);
    level_follow = 1'b1; level_sel = SW'(5); net_vals[5] = 32'd1;
    step(); check("R4 level net", 1'b0, 1'b1);
    mode_follow = 1'b0; level_follow = 1'b0; set_const(1'b0, 1'b0); net_vals[5] = '0;
    step(); check("R3 back const", 1'b0, 1'b0);
  endtask

  task automatic t_oor();
    for (int i = 0; i < NN; i++) net_vals[i] = 32'hFFFF_FFFF;
    mode_follow = 1'b1; mode_sel = SW'(9);
    step(); check("R5 out of range", 1'b0, 1'b0);
    mode_sel = SW'(7); step(); check("R5 last valid", 1'b1, 1'b0);
    mode_follow = 1'b0; mode_const = 1'b0;
    for (int i = 0; i < NN; i++) net_vals[i] = '0;
    step(); check("R5 restore", 1'b0, 1'b0);
  endtask

  task automatic t_lock();
    mode_cap_cnt = '0; mode_fixed = 1'b0; mode_const = 1'b1;
    step(); check("R6 mode locked", 1'b0, 1'b0);
    mode_cap_cnt = 2'd1; level_cap_cnt = '0; level_fixed = 1'b0; level_const = 1'b1;
    step(); check("R6 level locked low", 1'b1, 1'b0);
    mode_const = 1'b0; step(); check("R6 mode still toggles", 1'b0, 1'b0);
    level_follow = 1'b1; level_sel = SW'(2); net_vals[2] = 32'd5;
    step(); check("R6 net ignored", 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; net_vals = '0; pd_present = 1'b0;
    mode_follow = 1'b0; mode_const = 1'b0; mode_sel = '0; mode_cap_cnt = 2'd1; mode_fixed = 1'b0;
    level_follow = 1'b0; level_const = 1'b0; level_sel = '0; level_cap_cnt = 2'd1; level_fixed = 1'b0;
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step(); check("R1 after release", 1'b0, 1'b0);
    t_single();
    t_al_to_th();
    t_diag();
    t_pd();
    t_net();
    t_oor();
    t_lock();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule